// File: doc/BRIEF.md
# Flash Operation Sequencer

This block turns one whole flash operation into the series of single SPI flash transactions it needs. A client pulses `start` with an operation code, a starting flash address, a byte length and a system memory address. The block then drives a one-at-a-time transaction port towards an SPI shifting engine. It moves through write-enable, program or erase, busy polling, write-disable, bulk read and identification transactions, and it ends with a one-cycle `done` pulse together with an error flag.

Programming is cut at page boundaries. Erasing walks the range in fixed strides of several pages. Reads are cut into block-sized transfers. After every page program or sector erase, the device status is polled until its busy bit drops. An identification probe reads a 32-bit ID, decides whether a device answered, and derives the device capacity from one of the ID bytes. The transaction port uses a request/acknowledge pair: `txn_req` stays high with stable fields until the engine returns a one-cycle `txn_done`. `txn_rdata` is valid in that same cycle.

Top module: `flash_op_sequencer`

## Requirements
- R1: For operation codes 0 (program), 1 (erase) and 2 (read), a `start` with `length` of zero raises `done` and `err` in the next cycle and issues no transaction.
- R2: A program request of N bytes at address A is issued as page-program transactions (opcode 0x02, `txn_addr_en`=1, 24-bit address, byte count in `txn_len`). The first one runs only up to the end of A's page, then come whole pages, then the remainder. The memory address advances by each chunk.
- R3: Every page-program is preceded by write-enable (0x06). It is followed by status reads (0x05, `txn_len`=1) repeated while `txn_rdata` bit 0 is 1, and then by write-disable (0x04).
- R4: Erase (code 1) of N bytes from A issues, for each stride of ERASE_PAGES×PAGE_BYTES bytes, write-enable (0x06), sector-erase (0x20, `txn_len`=0, the stride's address), then status reads until bit 0 is clear. The number of strides is ceil(N / stride).
- R5: Read (code 2) of N bytes is issued as fast-read transactions (0x0B). Each covers BLOCK_BYTES bytes except a shorter last one. Flash and memory addresses both advance by each chunk.
- R6: Probe (code 3) issues one transaction with opcode 0x9F and `txn_len`=4. A returned ID of 0xFFFFFFFF ends with `err`=1.
- R7: After a successful probe, `cap_mbit` equals 1 shifted left by (ID[23:16] − 0x11), with the subtraction taken modulo 256 and the result truncated to 32 bits. `cap_mbit` changes only in the cycle `done` rises and is 0 after reset.
- R8: If the probe transaction is not acknowledged within ID_POLL_LIMIT cycles, the request is withdrawn. The operation then ends with `done` and `err` one cycle later.
- R9: `busy` is high from the cycle after an accepted non-empty start until `done`. A `start` that arrives while busy is ignored.
- R10: `done` lasts one cycle. `txn_req` is only high while busy, and its fields stay stable until `txn_done`.
- R11: After reset, `busy`, `done`, `err` and `txn_req` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Operation start pulse, taken when idle |
| op | input | 2 | 0 program, 1 erase, 2 read, 3 probe |
| flash_addr | input | ADDR_W | Starting flash byte address |
| length | input | LEN_W | Byte count (ignored by probe) |
| mem_addr | input | MEM_W | Starting system memory address |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Error result, valid with done |
| cap_mbit | output | 32 | Capacity in megabits from the last good probe |
| txn_req | output | 1 | Transaction request, held until txn_done |
| txn_opcode | output | 8 | Flash opcode of the transaction |
| txn_addr_en | output | 1 | Transaction carries a 24-bit address phase |
| txn_addr | output | ADDR_W | Transaction flash address |
| txn_len | output | LEN_W | Data byte count of the transaction |
| txn_mem_addr | output | MEM_W | Memory address for data movement |
| txn_done | input | 1 | Transaction finished (one cycle) |
| txn_rdata | input | 32 | Status or ID returned with txn_done |

## Verification
The bench targets page splitting at an unaligned start, a start exactly on a boundary and a request that ends inside its first page. A wrong split shows up as a program chunk that crosses a page, or as an extra or missing chunk. Erase lengths of one byte and of exactly two strides catch an off-by-one stride count. Read lengths just above one block catch a dropped tail transfer. Status polls with several busy replies catch a sequencer that stops polling early or skips write-disable. The probe is run against an absent device, against a silent engine (which would hang a design without a timeout) and against random ID bytes, where a wrong shift formula gives a different capacity. A start pulsed mid-operation would, if obeyed, corrupt the transaction stream.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

  typedef enum logic [1:0] {
    OP_PROGRAM = 2'd0,
    OP_ERASE   = 2'd1,
    OP_READ    = 2'd2,
    OP_PROBE   = 2'd3
  } fseq_op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WREN,
    ST_MAIN,
    ST_POLL,
    ST_WRDI
  } fseq_state_e;

  localparam logic [7:0] CMD_WREN = 8'h06;
  localparam logic [7:0] CMD_WRDI = 8'h04;
  localparam logic [7:0] CMD_PP   = 8'h02;
  localparam logic [7:0] CMD_SE   = 8'h20;
  localparam logic [7:0] CMD_RDSR = 8'h05;
  localparam logic [7:0] CMD_FRD  = 8'h0B;
  localparam logic [7:0] CMD_RDID = 8'h9F;

  localparam logic [7:0] CAP_BIAS = 8'h11;

  // capacity in megabits from the density byte of the ID
  function automatic logic [31:0] cap_from_density(input logic [7:0] dens);
    logic [7:0] sh;
    sh = dens - CAP_BIAS;
    if (sh > 8'd31) return 32'd0;
    return 32'd1 << sh[4:0];
  endfunction

  // smaller of the remaining count and the current limit
  function automatic logic [31:0] clip_len(input logic [31:0] rem, input logic [31:0] lim);
    return (rem < lim) ? rem : lim;
  endfunction

endpackage

// File: rtl/fseq_chunker.sv
module fseq_chunker
  import flash_seq_pkg::*;
#(
  parameter int LEN_W        = 24,
  parameter int PAGE_BYTES   = 256,
  parameter int BLOCK_BYTES  = 65536,
  parameter int ERASE_STRIDE = 4096
) (
  input  logic [1:0]                      op,
  input  logic [$clog2(PAGE_BYTES)-1:0]   page_off,
  input  logic [LEN_W-1:0]                rem,
  output logic [LEN_W-1:0]                chunk,
  output logic                            last
);
  localparam int PG_W = $clog2(PAGE_BYTES);

  logic [31:0] limit;
  logic [31:0] clipped;

  always_comb begin
    case (fseq_op_e'(op))
      OP_PROGRAM: limit = 32'(PAGE_BYTES) - {{(32-PG_W){1'b0}}, page_off};
      OP_ERASE:   limit = 32'(ERASE_STRIDE);
      default:    limit = 32'(BLOCK_BYTES);
    endcase
    clipped = clip_len(32'(rem), limit);
    chunk   = clipped[LEN_W-1:0];
    last    = (32'(rem) <= limit);
  end

endmodule

// File: rtl/fseq_watch.sv
module fseq_watch #(
  parameter int LIMIT = 500
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic hit
);
  localparam int CNT_W = $clog2(LIMIT + 1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (!en)    cnt <= '0;
    else if (!hit)   cnt <= cnt + 1'b1;
  end

  assign hit = en && (cnt == CNT_W'(LIMIT - 1));

endmodule

// File: rtl/fseq_capacity.sv
module fseq_capacity
  import flash_seq_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        load,
  input  logic [7:0]  density,
  output logic [31:0] cap_mbit
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cap_mbit <= '0;
    else if (load) cap_mbit <= cap_from_density(density);
  end
endmodule

// File: rtl/flash_op_sequencer.sv
module flash_op_sequencer
  import flash_seq_pkg::*;
#(
  parameter int ADDR_W        = 24,
  parameter int LEN_W         = 24,
  parameter int MEM_W         = 32,
  parameter int PAGE_BYTES    = 256,
  parameter int BLOCK_BYTES   = 65536,
  parameter int ERASE_PAGES   = 16,
  parameter int ID_POLL_LIMIT = 500
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [1:0]        op,
  input  logic [ADDR_W-1:0] flash_addr,
  input  logic [LEN_W-1:0]  length,
  input  logic [MEM_W-1:0]  mem_addr,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic [31:0]       cap_mbit,
  output logic              txn_req,
  output logic [7:0]        txn_opcode,
  output logic              txn_addr_en,
  output logic [ADDR_W-1:0] txn_addr,
  output logic [LEN_W-1:0]  txn_len,
  output logic [MEM_W-1:0]  txn_mem_addr,
  input  logic              txn_done,
  input  logic [31:0]       txn_rdata
);
  localparam int PG_W         = $clog2(PAGE_BYTES);
  localparam int ERASE_STRIDE = PAGE_BYTES * ERASE_PAGES;

  fseq_state_e       state;
  fseq_op_e          op_q;
  logic [ADDR_W-1:0] addr_q;
  logic [LEN_W-1:0]  rem_q;
  logic [MEM_W-1:0]  mem_q;
  logic              done_q, err_q;

  logic [LEN_W-1:0]  chunk;
  logic              last_chunk;

  // named events for the checker
  logic start_acc, start_empty, id_timeout, id_ack, step_adv, op_finish, fin_err;
  logic poll_busy, data_phase;

  fseq_chunker #(
    .LEN_W(LEN_W), .PAGE_BYTES(PAGE_BYTES),
    .BLOCK_BYTES(BLOCK_BYTES), .ERASE_STRIDE(ERASE_STRIDE)
  ) u_chunk (
    .op(op_q), .page_off(addr_q[PG_W-1:0]), .rem(rem_q),
    .chunk(chunk), .last(last_chunk)
  );

  logic watch_hit;
  fseq_watch #(.LIMIT(ID_POLL_LIMIT)) u_watch (
    .clk(clk), .rst_n(rst_n),
    .en(state == ST_MAIN && op_q == OP_PROBE),
    .hit(watch_hit)
  );

  logic id_good;
  assign id_ack  = (state == ST_MAIN) && (op_q == OP_PROBE) && txn_done;
  assign id_good = id_ack && (txn_rdata != 32'hFFFF_FFFF);

  fseq_capacity u_cap (
    .clk(clk), .rst_n(rst_n), .load(id_good),
    .density(txn_rdata[23:16]), .cap_mbit(cap_mbit)
  );

  assign start_acc   = (state == ST_IDLE) && start;
  assign start_empty = start_acc && (fseq_op_e'(op) != OP_PROBE) && (length == '0);
  assign id_timeout  = watch_hit && !txn_done;
  assign poll_busy   = txn_rdata[0];
  assign data_phase  = (state == ST_MAIN) && (op_q == OP_PROGRAM || op_q == OP_READ);

  // a chunk is consumed after: read ack, erase poll clear, write-disable ack
  always_comb begin
    step_adv = 1'b0;
    if (txn_done) begin
      case (state)
        ST_MAIN: step_adv = (op_q == OP_READ);
        ST_POLL: step_adv = !poll_busy && (op_q == OP_ERASE);
        ST_WRDI: step_adv = 1'b1;
        default: step_adv = 1'b0;
      endcase
    end
  end

  assign op_finish = start_empty || id_ack || id_timeout || (step_adv && last_chunk);
  assign fin_err   = start_empty || id_timeout || (id_ack && !id_good);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      op_q   <= OP_PROGRAM;
      addr_q <= '0;
      rem_q  <= '0;
      mem_q  <= '0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (op_finish) begin
        state  <= ST_IDLE;
        done_q <= 1'b1;
        err_q  <= fin_err;
      end else if (start_acc) begin
        op_q   <= fseq_op_e'(op);
        addr_q <= flash_addr;
        rem_q  <= length;
        mem_q  <= mem_addr;
        err_q  <= 1'b0;
        state  <= (fseq_op_e'(op) == OP_PROGRAM || fseq_op_e'(op) == OP_ERASE) ? ST_WREN : ST_MAIN;
      end else if (step_adv) begin
        addr_q <= addr_q + ADDR_W'(chunk);
        mem_q  <= mem_q + MEM_W'(chunk);
        rem_q  <= rem_q - chunk;
        state  <= (op_q == OP_READ) ? ST_MAIN : ST_WREN;
      end else if (txn_done) begin
        case (state)
          ST_WREN: state <= ST_MAIN;
          ST_MAIN: state <= ST_POLL;
          ST_POLL: if (!poll_busy) state <= ST_WRDI;
          default: state <= state;
        endcase
      end
    end
  end

  // transaction fields
  always_comb begin
    txn_opcode   = 8'h00;
    txn_addr_en  = 1'b0;
    txn_addr     = '0;
    txn_len      = '0;
    txn_mem_addr = '0;
    case (state)
      ST_WREN: txn_opcode = CMD_WREN;
      ST_WRDI: txn_opcode = CMD_WRDI;
      ST_POLL: begin
        txn_opcode = CMD_RDSR;
        txn_len    = LEN_W'(1);
      end
      ST_MAIN: begin
        case (op_q)
          OP_PROGRAM: txn_opcode = CMD_PP;
          OP_ERASE:   txn_opcode = CMD_SE;
          OP_READ:    txn_opcode = CMD_FRD;
          default:    txn_opcode = CMD_RDID;
        endcase
        if (op_q == OP_PROBE) txn_len = LEN_W'(4);
        else begin
          txn_addr_en = 1'b1;
          txn_addr    = addr_q;
        end
        if (data_phase) begin
          txn_len      = chunk;
          txn_mem_addr = mem_q;
        end
      end
      default: txn_opcode = 8'h00;
    endcase
  end

  assign txn_req = (state != ST_IDLE);
  assign busy    = (state != ST_IDLE);
  assign done    = done_q;
  assign err     = err_q;

endmodule

// File: rtl/fseq_checker.sv
module fseq_checker #(
  parameter int ADDR_W = 24,
  parameter int LEN_W  = 24,
  parameter int MEM_W  = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic [1:0]        op,
  input logic [LEN_W-1:0]  length,
  input logic              busy,
  input logic              done,
  input logic              err,
  input logic [31:0]       cap_mbit,
  input logic              txn_req,
  input logic              txn_done,
  input logic [7:0]        txn_opcode,
  input logic [ADDR_W-1:0] txn_addr,
  input logic [LEN_W-1:0]  txn_len,
  input logic [MEM_W-1:0]  txn_mem_addr,
  input logic              id_timeout
);

  p_zero_len_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && op != 2'd3 && length == '0) |=> (done && err));

  p_pp_then_poll_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (txn_req && txn_done && txn_opcode == 8'h02) |=> (txn_req && txn_opcode == 8'h05));

  p_wren_then_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (txn_req && txn_done && txn_opcode == 8'h06) |=>
      (txn_req && (txn_opcode == 8'h02 || txn_opcode == 8'h20)));

  p_se_then_poll_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (txn_req && txn_done && txn_opcode == 8'h20) |=> (txn_req && txn_opcode == 8'h05));

  p_cap_only_at_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cap_mbit) |-> done);

  p_timeout_ends_r8: assert property (@(posedge clk) disable iff (!rst_n)
    id_timeout |=> (done && err && !txn_req));

  p_start_runs_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && !(op != 2'd3 && length == '0)) |=> busy);

  p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_req_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    txn_req |-> busy);

  p_fields_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (txn_req && !txn_done) |=> (!txn_req ||
      ($stable(txn_opcode) && $stable(txn_addr) && $stable(txn_len) && $stable(txn_mem_addr))));

endmodule

bind flash_op_sequencer fseq_checker #(
  .ADDR_W(ADDR_W), .LEN_W(LEN_W), .MEM_W(MEM_W)
) u_fseq_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .op(op), .length(length),
  .busy(busy), .done(done), .err(err), .cap_mbit(cap_mbit),
  .txn_req(txn_req), .txn_done(txn_done), .txn_opcode(txn_opcode),
  .txn_addr(txn_addr), .txn_len(txn_len), .txn_mem_addr(txn_mem_addr),
  .id_timeout(id_timeout)
);

// File: tb/tb_flash_op_sequencer.sv
module tb_flash_op_sequencer;
  localparam int PAGE   = 256;
  localparam int BLOCK  = 65536;
  localparam int STRIDE = 16 * PAGE;
  localparam int IDLIM  = 500;

  typedef struct packed {
    logic [7:0]  opc;
    logic [23:0] addr;
    logic [23:0] len;
    logic [31:0] mem;
  } txn_t;

  logic clk = 0, rst_n = 0;
  logic start = 0;
  logic [1:0] op = 0;
  logic [23:0] flash_addr = 0, length = 0;
  logic [31:0] mem_addr = 0;
  logic busy, done, err, txn_req, txn_addr_en;
  logic [31:0] cap_mbit;
  logic [7:0] txn_opcode;
  logic [23:0] txn_addr, txn_len;
  logic [31:0] txn_mem_addr;
  logic txn_done = 0;
  logic [31:0] txn_rdata = 0;

  int checks = 0, errors = 0;
  txn_t log_q[$];
  txn_t exp_q[$];
  int busy_polls = 0;
  int polls_left = 0;
  int wait_n = 0;
  bit mute = 0;
  logic [31:0] id_val = 0;
  int cyc;

  always #10 clk = ~clk;

  flash_op_sequencer dut (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .flash_addr(flash_addr),
    .length(length), .mem_addr(mem_addr), .busy(busy), .done(done), .err(err),
    .cap_mbit(cap_mbit), .txn_req(txn_req), .txn_opcode(txn_opcode),
    .txn_addr_en(txn_addr_en), .txn_addr(txn_addr), .txn_len(txn_len),
    .txn_mem_addr(txn_mem_addr), .txn_done(txn_done), .txn_rdata(txn_rdata)
  );

  // transaction engine model
  always @(negedge clk) begin
    if (txn_done) txn_done = 0;
    else if (!txn_req) wait_n = 0;
    else if (!mute) begin
      if (wait_n == 0) begin
        log_q.push_back('{txn_opcode, txn_addr_en ? txn_addr : 24'h0, txn_len, txn_mem_addr});
        case (txn_opcode)
          8'h05: if (polls_left > 0) begin txn_rdata = 32'h0000_0003; polls_left--; end
                 else txn_rdata = 32'h0000_00FC;
          8'h9F: txn_rdata = id_val;
          8'h02, 8'h20: begin polls_left = busy_polls; txn_rdata = $urandom; end
          default: txn_rdata = $urandom;
        endcase
        txn_done = 1;
        wait_n = $urandom_range(0, 2);
      end else wait_n--;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic int min_i(input int a, input int b);
    return (a < b) ? a : b;
  endfunction

  task automatic push_exp(input logic [7:0] o, input int a, input int l, input int m);
    exp_q.push_back('{o, 24'(a), 24'(l), 32'(m)});
  endtask

  // expected transaction list, rebuilt from the requirement text
  task automatic build_exp(input int o, input int a, input int n, input int m);
    int room, c;
    exp_q.delete();
    if (o == 3) begin push_exp(8'h9F, 0, 4, 0); return; end
    while (n > 0) begin
      if (o == 0) begin
        room = PAGE - (a % PAGE);
        c = min_i(n, room);
        push_exp(8'h06, 0, 0, 0);
        push_exp(8'h02, a, c, m);
        for (int k = 0; k <= busy_polls; k++) push_exp(8'h05, 0, 1, 0);
        push_exp(8'h04, 0, 0, 0);
      end else if (o == 1) begin
        c = min_i(n, STRIDE);
        push_exp(8'h06, 0, 0, 0);
        push_exp(8'h20, a, 0, 0);
        for (int k = 0; k <= busy_polls; k++) push_exp(8'h05, 0, 1, 0);
      end else begin
        c = min_i(n, BLOCK);
        push_exp(8'h0B, a, c, m);
      end
      a += c; m += c; n -= c;
    end
  endtask

  task automatic run_op(input int o, input int a, input int n, input int m);
    log_q.delete();
    @(negedge clk);
    op = 2'(o); flash_addr = 24'(a); length = 24'(n); mem_addr = 32'(m); start = 1;
    @(negedge clk);
    start = 0;
    cyc = 1;
    while (!done && cyc < 20000) begin @(negedge clk); cyc++; end
  endtask

  task automatic cmp_log(input string req);
    int bad = -1;
    chk(log_q.size() == exp_q.size(), req, "transaction count", log_q.size(), exp_q.size());
    for (int i = 0; i < log_q.size() && i < exp_q.size(); i++)
      if (bad < 0 && log_q[i] != exp_q[i]) bad = i;
    if (bad >= 0) chk(0, req, $sformatf("transaction %0d", bad), log_q[bad], exp_q[bad]);
    else chk(1, req, "transactions", 0, 0);
  endtask

  function automatic logic [31:0] exp_cap(input logic [7:0] d);
    logic [7:0] s;
    logic [63:0] w;
    s = d - 8'h11;
    w = 64'd1 << s;
    return w[31:0];
  endfunction

  task automatic do_mem(input int o, input int a, input int n, input int m, input string req);
    build_exp(o, a, n, m);
    run_op(o, a, n, m);
    chk(done && !err, req, "done without error", {done, err}, 2'b10);
    cmp_log(req);
  endtask

  task automatic do_probe(input logic [31:0] id);
    logic [31:0] prev;
    prev = cap_mbit;
    id_val = id;
    build_exp(3, 0, 0, 0);
    run_op(3, 0, 0, 0);
    cmp_log("R6");
    if (id == 32'hFFFF_FFFF) begin
      chk(err, "R6", "absent device error", err, 1);
      chk(cap_mbit == prev, "R7", "capacity kept", cap_mbit, prev);
    end else begin
      chk(!err, "R6", "present device ok", err, 0);
      chk(cap_mbit == exp_cap(id[23:16]), "R7", "capacity", cap_mbit, exp_cap(id[23:16]));
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R11 reset state
    chk({busy, done, err, txn_req} == 4'b0, "R11", "idle after reset", {busy, done, err, txn_req}, 0);
    chk(cap_mbit == 0, "R7", "capacity after reset", cap_mbit, 0);

    // R1 empty requests
    for (int o = 0; o < 3; o++) begin
      run_op(o, 24'h100, 0, 0);
      chk(cyc == 1 && done && err, "R1", "empty request ends at once", {cyc[7:0], done, err}, {8'd1, 2'b11});
      chk(log_q.size() == 0, "R1", "no transactions", log_q.size(), 0);
    end

    // R2 R3 program splitting
    busy_polls = 2; do_mem(0, 24'h0000F0, 600, 32'h1000, "R2");
    busy_polls = 0; do_mem(0, 24'h000200, 256, 32'h2000, "R2");
    busy_polls = 3; do_mem(0, 24'h000010, 5, 32'h3000, "R3");
    busy_polls = 1; do_mem(0, 24'h0001FF, 2, 32'h4000, "R2");

    // R4 erase strides
    busy_polls = 2; do_mem(1, 24'h001000, 2 * STRIDE, 0, "R4");
    busy_polls = 0; do_mem(1, 24'h003000, 1, 0, "R4");
    busy_polls = 1; do_mem(1, 24'h002000, STRIDE + 1, 0, "R4");

    // R5 chunked read
    do_mem(2, 24'h010000, BLOCK + 4464, 32'h8000_0000, "R5");
    do_mem(2, 24'h000000, BLOCK, 32'h0, "R5");
    do_mem(2, 24'h000033, 7, 32'h40, "R5");

    // R6 R7 probe
    do_probe(32'h00C2_1420);
    do_probe(32'h0011_0000);
    do_probe(32'hFFFF_FFFF);
    for (int i = 0; i < 4; i++) do_probe({8'h00, 8'($urandom_range(8'h11, 8'h40)), 16'($urandom)});

    // R8 probe timeout
    mute = 1;
    run_op(3, 0, 0, 0);
    mute = 0;
    chk(done && err, "R8", "timeout error", {done, err}, 2'b11);
    chk(cyc == IDLIM + 1, "R8", "timeout cycle", cyc, IDLIM + 1);
    chk(log_q.size() == 0 && !txn_req, "R8", "request withdrawn", {log_q.size(), txn_req}, 0);

    // R9 start while busy is ignored
    busy_polls = 1;
    build_exp(0, 24'h0000F0, 600, 32'h5000);
    log_q.delete();
    @(negedge clk);
    op = 0; flash_addr = 24'h0000F0; length = 600; mem_addr = 32'h5000; start = 1;
    @(negedge clk); start = 0;
    repeat (6) @(negedge clk);
    op = 2; flash_addr = 24'h123456; length = 10; start = 1;
    @(negedge clk); start = 0;
    chk(busy, "R9", "still busy", busy, 1);
    cyc = 0;
    while (!done && cyc < 20000) begin @(negedge clk); cyc++; end
    cmp_log("R9");
    @(negedge clk);
    chk(!done && !busy, "R10", "done is one cycle", {done, busy}, 0);

    // random mix
    for (int i = 0; i < 20; i++) begin
      int o, a, n;
      o = $urandom_range(0, 2);
      a = $urandom_range(0, 24'h7FFFFF);
      busy_polls = $urandom_range(0, 3);
      n = (o == 0) ? $urandom_range(1, 1200) : (o == 1) ? $urandom_range(1, 3 * STRIDE) : $urandom_range(1, 140000);
      do_mem(o, a, n, $urandom, o == 0 ? "R2" : o == 1 ? "R4" : "R5");
    end

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule